// File: doc/BRIEF.md
# MII Management Register Controller

This block gives a host two registers through which it performs single management reads and writes on an external PHY. The host writes a packed control word. That word carries the PHY address, the PHY register number and two start bits. The block then serialises a complete management frame on MDIO. It produces MDC by dividing the system clock, and it releases MDIO for the reply when the operation is a read. When the frame ends, the block clears the start bit itself.

For a write, the host first loads the 16-bit value into the data register, then writes the control word with the write bit set. For a read, the host sets the read bit and polls it. Once the bit returns to zero, the data register holds the value the PHY returned. MDC is high for `HALF_DIV` system cycles and low for `HALF_DIV` system cycles. With the default of 20 at a 100 MHz system clock, MDC runs at 2.5 MHz.

Top module: `mii_mgmt_ctl`

## Requirements
- R1: After reset the control readback and the data readback are both zero, and MDC and the MDIO output enable are both low.
- R2: In the control word, bits 8:4 hold the register number and bits 13:9 hold the PHY address. Both read back as written. Bits 3:2 and 15:14 read as zero. A control write with bits 1:0 both zero starts no frame.
- R3: Writing control bit 0 as 1 starts a read. The bit reads 1 until the frame is over and then reads 0.
- R4: Writing control bit 1 as 1 (with bit 0 clear) starts a write. The bit reads 1 until the frame is over and then reads 0.
- R5: A write frame, sampled on rising MDC edges, is 32 ones, then 01, then 01, then the PHY address and the register number (each MSB first), then 10, then the 16 data-register bits MSB first. The output enable stays high for the whole frame.
- R6: A read frame sends 32 ones, then 01, then 10, then the PHY address and the register number. The output enable goes low from the first turnaround bit to the end of the frame.
- R7: After a read, the data register holds the 16 MDIO values sampled on the rising MDC edges of the last 16 bit slots, with the first sample as the MSB.
- R8: While a frame is in progress, writes to the control register and writes to the data register are both ignored.
- R9: Each MDC half period lasts `HALF_DIV` system cycles. The start bit clears exactly 2 × (PRE_BITS + 32) × `HALF_DIV` cycles after the clock edge that accepts the control write.
- R10: When bits 0 and 1 are written as 1 together, only a read is performed, and bit 1 reads back as 0.
- R11: While no frame is in progress, MDC is low and the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Host register write strobe |
| regSel | input | 1 | 0 selects the control register, 1 selects the data register |
| regWrData | input | 16 | Host write data |
| ctrlWord | output | 16 | Control register readback, including the live start bits |
| dataWord | output | 16 | Data register readback |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | MDIO output value |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO input value |

## Verification
The bench builds the block with `HALF_DIV` set to 2 and `PRE_BITS` left at 32. A frame then takes 256 system cycles, so many back-to-back frames fit in a short run. The small divider also lets the exact completion cycle of R9 be counted directly. A behavioural PHY on the bench side records every bit and output-enable value on the rising MDC edges and supplies read data on the falling edges. This covers the write layout, the read layout, the turnaround release, and the data capture edge. The same setup covers the writes issued in the middle of a frame, which must not alter the frame or the registers.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;
  // Control word field positions (software visible)
  localparam int RD_BIT    = 0;
  localparam int WR_BIT    = 1;
  localparam int REG_LSB   = 4;
  localparam int PHY_LSB   = 9;
  localparam int ADDR_BITS = 5;
  localparam int DATA_BITS = 16;

  // Strobes from sequencer to datapath
  typedef struct packed {
    logic ctlWrite;   // accept control field update
    logic dataWrite;  // accept data register update
    logic load;       // build and load frame shifter
    logic shift;      // advance to next frame bit (MDC falling)
    logic sample;     // capture MDIO input (MDC rising)
    logic done;       // frame finished
  } mgmtStrobe_t;
endpackage

// File: rtl/mii_mgmt_ctrl.sv
module mii_mgmt_ctrl
  import mii_mgmt_pkg::*;
#(
  parameter int HALF_DIV = 20,
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regSel,
  input  logic [1:0]  startBits,
  output mgmtStrobe_t stb,
  output logic        mdc,
  output logic        mdioOe
);
  localparam int FRAME_LEN = PRE_BITS + 32;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int DIV_W     = $clog2(HALF_DIV + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_BITS + 14);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(PRE_BITS + 16);
  localparam logic [DIV_W-1:0] DIV_END  = DIV_W'(HALF_DIV - 1);

  logic             busy;
  logic             isRead;
  logic             mdcQ;
  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             tick;
  logic             startReq;

  assign tick     = busy && (divCnt == DIV_END);
  assign startReq = regWrEn && !regSel && !busy && (startBits != 2'b00);

  always_comb begin
    stb           = '0;
    stb.ctlWrite  = regWrEn && !regSel && !busy;
    stb.dataWrite = regWrEn && regSel && !busy;
    stb.load      = startReq;
    stb.sample    = tick && !mdcQ && isRead && (bitIdx >= DATA_IDX);
    stb.shift     = tick && mdcQ && (bitIdx != LAST_IDX);
    stb.done      = tick && mdcQ && (bitIdx == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      isRead <= 1'b0;
      mdcQ   <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (!busy) begin
      if (startReq) begin
        busy   <= 1'b1;
        isRead <= startBits[RD_BIT];
        mdcQ   <= 1'b0;
        divCnt <= '0;
        bitIdx <= '0;
      end
    end else if (tick) begin
      divCnt <= '0;
      if (!mdcQ) begin
        mdcQ <= 1'b1;
      end else begin
        mdcQ <= 1'b0;
        if (bitIdx == LAST_IDX) busy <= 1'b0;
        else                    bitIdx <= bitIdx + 1'b1;
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign mdc    = mdcQ;
  assign mdioOe = busy && !(isRead && (bitIdx >= TA_IDX));
endmodule

// File: rtl/mii_mgmt_dpath.sv
module mii_mgmt_dpath
  import mii_mgmt_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  mgmtStrobe_t stb,
  input  logic [15:0] wrData,
  input  logic        mdioIn,
  output logic [15:0] ctrlWord,
  output logic [15:0] dataWord,
  output logic        mdioOut
);
  localparam int FRAME_LEN = PRE_BITS + 32;

  logic                 rdBit;
  logic                 wrBit;
  logic [ADDR_BITS-1:0] phyAddr;
  logic [ADDR_BITS-1:0] regAddr;
  logic [DATA_BITS-1:0] dataReg;
  logic [DATA_BITS-1:0] rdShift;
  logic [FRAME_LEN-1:0] frameSr;
  logic [FRAME_LEN-1:0] frameNew;
  logic                 newRd;

  assign newRd = wrData[RD_BIT];

  always_comb begin
    frameNew = {{PRE_BITS{1'b1}}, 2'b01,
                (newRd ? 2'b10 : 2'b01),
                wrData[PHY_LSB +: ADDR_BITS],
                wrData[REG_LSB +: ADDR_BITS],
                (newRd ? 2'b11 : 2'b10),
                dataReg};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdBit   <= 1'b0;
      wrBit   <= 1'b0;
      phyAddr <= '0;
      regAddr <= '0;
      dataReg <= '0;
      rdShift <= '0;
      frameSr <= '1;
    end else begin
      if (stb.ctlWrite) begin
        phyAddr <= wrData[PHY_LSB +: ADDR_BITS];
        regAddr <= wrData[REG_LSB +: ADDR_BITS];
        rdBit   <= wrData[RD_BIT];
        wrBit   <= wrData[WR_BIT] & ~wrData[RD_BIT];
      end
      if (stb.dataWrite) dataReg <= wrData;
      if (stb.load)      frameSr <= frameNew;
      else if (stb.shift) frameSr <= {frameSr[FRAME_LEN-2:0], 1'b1};
      if (stb.sample)    rdShift <= {rdShift[DATA_BITS-2:0], mdioIn};
      if (stb.done) begin
        rdBit <= 1'b0;
        wrBit <= 1'b0;
        if (rdBit) dataReg <= rdShift;
      end
    end
  end

  assign ctrlWord = {2'b00, phyAddr, regAddr, 2'b00, wrBit, rdBit};
  assign dataWord = dataReg;
  assign mdioOut  = frameSr[FRAME_LEN-1];
endmodule

// File: rtl/mii_mgmt_ctl.sv
module mii_mgmt_ctl
  import mii_mgmt_pkg::*;
#(
  parameter int HALF_DIV = 20,
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regSel,
  input  logic [15:0] regWrData,
  output logic [15:0] ctrlWord,
  output logic [15:0] dataWord,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mgmtStrobe_t stb;

  mii_mgmt_ctrl #(.HALF_DIV(HALF_DIV), .PRE_BITS(PRE_BITS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .startBits (regWrData[1:0]),
    .stb       (stb),
    .mdc       (mdc),
    .mdioOe    (mdioOe)
  );

  mii_mgmt_dpath #(.PRE_BITS(PRE_BITS)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (regWrData),
    .mdioIn   (mdioIn),
    .ctrlWord (ctrlWord),
    .dataWord (dataWord),
    .mdioOut  (mdioOut)
  );
endmodule

// File: rtl/mii_mgmt_chk.sv
module mii_mgmt_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] ctrlWord,
  input logic [15:0] dataWord,
  input logic        mdc,
  input logic        mdioOe
);
  logic active;
  assign active = ctrlWord[1:0] != 2'b00;

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (!mdc && !mdioOe));

  p_write_drives_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWord[1] |-> mdioOe);

  p_single_op_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrlWord[0] && ctrlWord[1]));

  p_fields_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(active) && active) |-> $stable(ctrlWord[15:2]));

  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctrlWord[1]) && ctrlWord[1]) |-> $stable(dataWord));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord[3:2] == 2'b00) && (ctrlWord[15:14] == 2'b00));
endmodule

bind mii_mgmt_ctl mii_mgmt_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .ctrlWord (ctrlWord),
  .dataWord (dataWord),
  .mdc      (mdc),
  .mdioOe   (mdioOe)
);

// File: tb/sim_mii_mgmt_ctl.sv
`timescale 1ns/1ps
module sim_mii_mgmt_ctl;
  localparam int HALF = 2;
  localparam int FLEN = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] ctrlWord, dataWord;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int nChk = 0;
  int nBad = 0;

  // PHY model state
  logic [63:0] capBits = '0;
  logic [63:0] capOe = '0;
  int          riseCnt = 0;
  logic [15:0] phyVal = '0;

  always #5 clk = ~clk;

  mii_mgmt_ctl #(.HALF_DIV(HALF), .PRE_BITS(32)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .ctrlWord(ctrlWord), .dataWord(dataWord),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always @(posedge mdc) begin
    capBits <= {capBits[62:0], mdioOut};
    capOe   <= {capOe[62:0], mdioOe};
    riseCnt <= riseCnt + 1;
  end

  always @(negedge mdc) begin
    if ((riseCnt % FLEN) >= 48) mdioIn = phyVal[63 - (riseCnt % FLEN)];
    else                        mdioIn = 1'b1;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic sel, input logic [15:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  function automatic logic [15:0] ctl(input logic [4:0] phy, input logic [4:0] rg, input logic [1:0] go);
    return {2'b00, phy, rg, 2'b00, go};
  endfunction

  task automatic waitIdle(output int cycles);
    cycles = 0;
    while (ctrlWord[1:0] != 2'b00) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic tReset;
    check("R1 ctrl", ctrlWord, 0);
    check("R1 data", dataWord, 0);
    check("R1 mdc/oe", {mdc, mdioOe}, 0);
  endtask

  task automatic tFields;
    int c;
    hostWrite(1'b0, 16'hFFFC);
    check("R2 fields readback", ctrlWord, 16'h3FF0);
    repeat (10) @(negedge clk);
    check("R2 no start", ctrlWord[1:0], 0);
    check("R11 idle mdc/oe", {mdc, mdioOe}, 0);
    check("R2 no frame", riseCnt, 0);
    hostWrite(1'b0, ctl(5'h0A, 5'h15, 2'b00));
    check("R2 field layout", ctrlWord, 16'h1550);
    c = 0;
  endtask

  task automatic tWrite(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    int cyc;
    hostWrite(1'b1, d);
    hostWrite(1'b0, ctl(phy, rg, 2'b10));
    check("R4 write busy", ctrlWord[1:0], 2'b10);
    waitIdle(cyc);
    check("R9 write duration", cyc, 2 * FLEN * HALF);
    check("R4 write cleared", ctrlWord[1:0], 0);
    check("R5 write frame", capBits, {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, d});
    check("R5 write oe", capOe, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R11 after write", {mdc, mdioOe}, 0);
  endtask

  task automatic tRead(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] v);
    int cyc;
    phyVal = v;
    hostWrite(1'b0, ctl(phy, rg, 2'b01));
    check("R3 read busy", ctrlWord[1:0], 2'b01);
    waitIdle(cyc);
    check("R9 read duration", cyc, 2 * FLEN * HALF);
    check("R3 read cleared", ctrlWord[1:0], 0);
    check("R6 read header", capBits[63:18], {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg});
    check("R6 read oe", capOe, 64'hFFFF_FFFF_FFFC_0000);
    check("R7 read data", dataWord, v);
  endtask

  task automatic tBusyIgnore;
    int cyc;
    hostWrite(1'b1, 16'hA5A5);
    hostWrite(1'b0, ctl(5'h03, 5'h05, 2'b10));
    repeat (20) @(negedge clk);
    hostWrite(1'b0, ctl(5'h1F, 5'h1F, 2'b01));
    hostWrite(1'b1, 16'h1234);
    check("R8 ctrl during busy", ctrlWord, ctl(5'h03, 5'h05, 2'b10));
    waitIdle(cyc);
    check("R8 ctrl after", ctrlWord, ctl(5'h03, 5'h05, 2'b00));
    check("R8 data kept", dataWord, 16'hA5A5);
    check("R8 frame intact", capBits, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h03, 5'h05, 2'b10, 16'hA5A5});
    repeat (10) @(negedge clk);
    check("R8 no late start", {ctrlWord[1:0], mdc}, 0);
  endtask

  task automatic tBoth;
    int cyc;
    phyVal = 16'h0F0F;
    hostWrite(1'b0, ctl(5'h02, 5'h01, 2'b11));
    check("R10 both bits", ctrlWord[1:0], 2'b01);
    waitIdle(cyc);
    check("R10 read performed", capBits[63:18], {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h02, 5'h01});
    check("R10 data", dataWord, 16'h0F0F);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tReset();
    tFields();
    tWrite(5'h01, 5'h00, 16'hBEEF);
    tWrite(5'h1E, 5'h1F, 16'h0001);
    tRead(5'h11, 5'h02, 16'hC35A);
    tRead(5'h00, 5'h10, 16'h8001);
    tBusyIgnore();
    tBoth();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule